// File: doc/BRIEF.md
# LIN Slave Response Controller

This block handles the response part of a LIN frame on a slave node. It starts once the header has been processed and the frame identifier is presented with a one-cycle strobe. A parameter table, indexed by identifier, tells the controller what to do with the frame. It either publishes the contents of its local byte buffer onto the bus, subscribes and stores the bytes that another node sends, or leaves the frame alone. The top two identifier bits set how many data bytes the response carries.

Each response is a run of UART-framed data bytes followed by one checksum byte. The checksum is the inverted 8-bit sum of the data bytes, with every carry out of bit 7 added back into bit 0. While publishing, the controller reads the bus back in the middle of each bit and stops at the first bit that does not match. While subscribing, it checks the received checksum and marks the buffer valid only when the checksum matches. If the next byte does not start within a bounded time, the controller drops the frame. The application loads and reads the buffer through a simple byte port.

Top module: `lin_resp_ctrl`

## Requirements
- R1: After reset the bus output `lin_tx` is recessive (1), and `busy`, `done`, `csum_err`, `bit_err` and `rx_valid` are all low.
- R2: An identifier accepted while idle is handled by the mask tables. If its bit in `PUB_MASK` is set, the controller transmits. Otherwise, if its bit in `SUB_MASK` is set, the controller receives. With neither bit set, `busy` stays low, `lin_tx` stays 1 and `rx_valid` keeps its value.
- R3: Identifier bits 5:4 give the number of data bytes: 00 or 01 gives 2, 10 gives 4 and 11 gives 8. Exactly that many data bytes plus one checksum byte are sent or expected.
- R4: Every byte is framed as a start bit of 0, then eight data bits with the LSB first, then a stop bit of 1. Each bit lasts `CLKS_PER_BIT` clocks. When publishing, data bytes are sent from buffer address 0 upward, and the checksum byte follows them.
- R5: The checksum byte is the bitwise inverse of the running 8-bit sum of the data bytes, where each carry out of bit 7 is added back into bit 0.
- R6: When subscribing, data byte k is written to buffer address k. If the received checksum equals the computed one, `rx_valid` goes to 1 and `done` pulses.
- R7: When subscribing and the checksum does not match, `csum_err` goes to 1, `rx_valid` stays 0 and `done` pulses.
- R8: When publishing, the controller compares the bus with the driven bit at mid-bit. On a mismatch it sets `bit_err`, stops transmitting, returns `lin_tx` to 1 and gives no `done` pulse.
- R9: When subscribing, if no start bit arrives within `TIMEOUT_CLKS` clocks of frame acceptance or of the previous byte, the controller returns to idle. In that case it gives no `done` pulse and `rx_valid` stays 0.
- R10: An identifier strobe that arrives while `busy` is high has no effect on the frame in progress.
- R11: `done` is a one-cycle pulse. `csum_err` and `bit_err` hold their value until the next identifier that is accepted for transmit or receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | One-cycle strobe: `id` holds a frame identifier |
| id | input | ID_W | Frame identifier |
| app_we | input | 1 | Application write enable for the buffer |
| app_addr | input | clog2(LONG_LEN) | Application buffer address for write and read |
| app_wdata | input | 8 | Application write data |
| app_rdata | output | 8 | Buffer contents at `app_addr` |
| lin_rx | input | 1 | Bus level read back |
| lin_tx | output | 1 | Bus drive, 0 is dominant |
| busy | output | 1 | A response is in progress |
| done | output | 1 | Pulse when a response completes |
| csum_err | output | 1 | Last received checksum was wrong |
| bit_err | output | 1 | Last transmission saw a readback mismatch |
| rx_valid | output | 1 | Buffer holds a response received with a correct checksum |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 8 and `TIMEOUT_CLKS` = 200. These values keep each byte near 80 clocks, so all three response lengths fit in a short run in both directions, and they let the inter-byte timeout expire well inside the run. The mask tables mark one publish identifier and one subscribe identifier for each length code, and they leave identifier 0x07 unlisted so the ignore path can be tested. The bus is modelled as a wired AND of the block's drive and a bench driver. This lets the bench inject a dominant level on top of a recessive data bit and trigger the readback fault.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

  typedef enum logic [1:0] {
    ACT_IGNORE    = 2'd0,
    ACT_PUBLISH   = 2'd1,
    ACT_SUBSCRIBE = 2'd2
  } resp_act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_RX   = 2'd2
  } resp_st_e;

  // 8-bit add with the carry folded back into bit 0
  function automatic logic [7:0] csum_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/lin_id_decode.sv
module lin_id_decode
  import lin_resp_pkg::*;
#(
  parameter int ID_W      = 6,
  parameter int LW        = 4,
  parameter int SHORT_LEN = 2,
  parameter int MID_LEN   = 4,
  parameter int LONG_LEN  = 8,
  parameter logic [(1<<ID_W)-1:0] PUB_MASK = '0,
  parameter logic [(1<<ID_W)-1:0] SUB_MASK = '0
) (
  input  logic [ID_W-1:0] id,
  output resp_act_e       act,
  output logic [LW-1:0]   len
);

  always_comb begin
    if (PUB_MASK[id])      act = ACT_PUBLISH;
    else if (SUB_MASK[id]) act = ACT_SUBSCRIBE;
    else                   act = ACT_IGNORE;
  end

  always_comb begin
    case (id[ID_W-1:ID_W-2])
      2'b10:   len = LW'(MID_LEN);
      2'b11:   len = LW'(LONG_LEN);
      default: len = LW'(SHORT_LEN);
    endcase
  end

endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  input  logic       line_rx,
  output logic       line_tx,
  output logic       done,
  output logic       err
);

  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int MIDC = CLKS_PER_BIT / 2;

  logic          busy_q, busy_d;
  logic [9:0]    sh_q, sh_d;
  logic [3:0]    bit_q, bit_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          err_q, err_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, data, 1'b0};
        bit_d  = '0;
        cnt_d  = '0;
      end
    end else if (cnt_q == CW'(MIDC) && line_rx != sh_q[0]) begin
      busy_d = 1'b0;
      err_d  = 1'b1;
    end else if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
      cnt_d = '0;
      sh_d  = {1'b1, sh_q[9:1]};
      if (bit_q == 4'd9) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        bit_d = bit_q + 4'd1;
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign line_tx = !busy_q | sh_q[0];
  assign done    = done_q;
  assign err     = err_q;

endmodule

// File: rtl/lin_uart_rx.sv
module lin_uart_rx #(
  parameter int CLKS_PER_BIT = 16,
  parameter int TIMEOUT_CLKS = 320
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       line_rx,
  output logic       byte_vld,
  output logic [7:0] byte_out,
  output logic       timeout
);

  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int TW   = $clog2(TIMEOUT_CLKS + 1);
  localparam int MIDC = CLKS_PER_BIT / 2;

  logic          act_q, act_d;
  logic [3:0]    bit_q, bit_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d;
  logic [TW-1:0] wait_q, wait_d;
  logic          vld_q, vld_d;
  logic          tmo_q, tmo_d;

  always_comb begin
    act_d  = act_q;
    bit_d  = bit_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    wait_d = wait_q;
    vld_d  = 1'b0;
    tmo_d  = 1'b0;
    if (!en) begin
      act_d  = 1'b0;
      wait_d = '0;
    end else if (!act_q) begin
      if (!line_rx) begin
        act_d = 1'b1;
        cnt_d = '0;
        bit_d = '0;
      end else if (wait_q == TW'(TIMEOUT_CLKS - 1)) begin
        tmo_d  = 1'b1;
        wait_d = '0;
      end else begin
        wait_d = wait_q + TW'(1);
      end
    end else begin
      if (cnt_q == CW'(MIDC)) begin
        if (bit_q == 4'd0) begin
          if (line_rx) act_d = 1'b0;
        end else if (bit_q == 4'd9) begin
          act_d  = 1'b0;
          wait_d = '0;
          vld_d  = 1'b1;
        end else begin
          sh_d = {line_rx, sh_q[7:1]};
        end
      end
      if (cnt_q == CW'(CLKS_PER_BIT - 1)) begin
        cnt_d = '0;
        bit_d = bit_q + 4'd1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      wait_q <= '0;
      vld_q  <= 1'b0;
      tmo_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      bit_q  <= bit_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      wait_q <= wait_d;
      vld_q  <= vld_d;
      tmo_q  <= tmo_d;
    end
  end

  assign byte_vld = vld_q;
  assign byte_out = sh_q;
  assign timeout  = tmo_q;

endmodule

// File: rtl/lin_resp_ctrl.sv
module lin_resp_ctrl
  import lin_resp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int TIMEOUT_CLKS = 320,
  parameter int ID_W         = 6,
  parameter int SHORT_LEN    = 2,
  parameter int MID_LEN      = 4,
  parameter int LONG_LEN     = 8,
  parameter logic [(1<<ID_W)-1:0] PUB_MASK = 64'h0000_0000_FFFF_0000,
  parameter logic [(1<<ID_W)-1:0] SUB_MASK = 64'h0000_0000_0000_FFFF,
  localparam int AW = $clog2(LONG_LEN),
  localparam int LW = $clog2(LONG_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_valid,
  input  logic [ID_W-1:0] id,
  input  logic            app_we,
  input  logic [AW-1:0]   app_addr,
  input  logic [7:0]      app_wdata,
  output logic [7:0]      app_rdata,
  input  logic            lin_rx,
  output logic            lin_tx,
  output logic            busy,
  output logic            done,
  output logic            csum_err,
  output logic            bit_err,
  output logic            rx_valid
);

  resp_act_e     dec_act;
  logic [LW-1:0] dec_len;

  lin_id_decode #(
    .ID_W(ID_W), .LW(LW), .SHORT_LEN(SHORT_LEN), .MID_LEN(MID_LEN),
    .LONG_LEN(LONG_LEN), .PUB_MASK(PUB_MASK), .SUB_MASK(SUB_MASK)
  ) u_dec (
    .id (id),
    .act(dec_act),
    .len(dec_len)
  );

  resp_st_e      st_q, st_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [LW-1:0] len_q, len_d;
  logic [7:0]    sum_q, sum_d;
  logic          txs_q, txs_d;
  logic          done_q, done_d;
  logic          cerr_q, cerr_d;
  logic          berr_q, berr_d;
  logic          rxv_q, rxv_d;
  logic [7:0]    buf_q [LONG_LEN];
  logic          bw_en;
  logic [AW-1:0] bw_addr;
  logic [7:0]    bw_data;

  logic       tx_done, tx_err;
  logic [7:0] tx_data;
  logic       rx_vld, rx_tmo;
  logic [7:0] rx_byte;
  logic [7:0] cur_byte;

  assign cur_byte = buf_q[idx_q[AW-1:0]];
  assign tx_data  = (idx_q == len_q) ? ~sum_q : cur_byte;

  lin_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (txs_q),
    .data   (tx_data),
    .line_rx(lin_rx),
    .line_tx(lin_tx),
    .done   (tx_done),
    .err    (tx_err)
  );

  lin_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (st_q == ST_RX),
    .line_rx (lin_rx),
    .byte_vld(rx_vld),
    .byte_out(rx_byte),
    .timeout (rx_tmo)
  );

  // Sequencer next state
  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    len_d  = len_q;
    sum_d  = sum_q;
    txs_d  = 1'b0;
    done_d = 1'b0;
    cerr_d = cerr_q;
    berr_d = berr_q;
    rxv_d  = rxv_q;
    bw_en  = 1'b0;
    bw_addr = app_addr;
    bw_data = app_wdata;
    case (st_q)
      ST_IDLE: begin
        if (id_valid && dec_act != ACT_IGNORE) begin
          idx_d  = '0;
          len_d  = dec_len;
          sum_d  = '0;
          cerr_d = 1'b0;
          berr_d = 1'b0;
          if (dec_act == ACT_PUBLISH) begin
            st_d  = ST_TX;
            txs_d = 1'b1;
          end else begin
            st_d  = ST_RX;
            rxv_d = 1'b0;
          end
        end
      end
      ST_TX: begin
        if (tx_err) begin
          berr_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (tx_done) begin
          if (idx_q == len_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            sum_d = csum_add(sum_q, cur_byte);
            idx_d = idx_q + LW'(1);
            txs_d = 1'b1;
          end
        end
      end
      ST_RX: begin
        if (rx_tmo) begin
          st_d = ST_IDLE;
        end else if (rx_vld) begin
          if (idx_q == len_q) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
            if (rx_byte == ~sum_q) rxv_d  = 1'b1;
            else                   cerr_d = 1'b1;
          end else begin
            bw_en   = 1'b1;
            bw_addr = idx_q[AW-1:0];
            bw_data = rx_byte;
            sum_d   = csum_add(sum_q, rx_byte);
            idx_d   = idx_q + LW'(1);
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      len_q  <= '0;
      sum_q  <= '0;
      txs_q  <= 1'b0;
      done_q <= 1'b0;
      cerr_q <= 1'b0;
      berr_q <= 1'b0;
      rxv_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      len_q  <= len_d;
      sum_q  <= sum_d;
      txs_q  <= txs_d;
      done_q <= done_d;
      cerr_q <= cerr_d;
      berr_q <= berr_d;
      rxv_q  <= rxv_d;
    end
  end

  // Local buffer: received bytes take priority over application writes
  generate
    for (genvar g = 0; g < LONG_LEN; g++) begin : g_buf
      logic hit_rx, hit_app;
      assign hit_rx  = bw_en && (bw_addr == AW'(g));
      assign hit_app = app_we && (app_addr == AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       buf_q[g] <= '0;
        else if (hit_rx)  buf_q[g] <= bw_data;
        else if (hit_app) buf_q[g] <= app_wdata;
      end
    end
  endgenerate

  assign app_rdata = buf_q[app_addr];
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign csum_err  = cerr_q;
  assign bit_err   = berr_q;
  assign rx_valid  = rxv_q;

endmodule

// File: rtl/lin_resp_ctrl_chk.sv
module lin_resp_ctrl_chk #(
  parameter int ID_W = 6,
  parameter logic [(1<<ID_W)-1:0] PUB_MASK = '0,
  parameter logic [(1<<ID_W)-1:0] SUB_MASK = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            id_valid,
  input logic [ID_W-1:0] id,
  input logic            busy,
  input logic            lin_tx,
  input logic            done,
  input logic            csum_err,
  input logic            bit_err,
  input logic            rx_valid
);

  a_r8_idle_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lin_tx);

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_csum_excl: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |-> !rx_valid);

  a_r2_ignore_id: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !busy && !PUB_MASK[id] && !SUB_MASK[id]) |=> !busy);

  a_r8_bit_err_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bit_err) |-> (!done && $past(busy)));

  a_r6_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> done);

endmodule

bind lin_resp_ctrl lin_resp_ctrl_chk #(
  .ID_W(ID_W), .PUB_MASK(PUB_MASK), .SUB_MASK(SUB_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id(id), .busy(busy),
  .lin_tx(lin_tx), .done(done), .csum_err(csum_err), .bit_err(bit_err),
  .rx_valid(rx_valid)
);

// File: tb/lin_resp_ctrl_tb.sv
module lin_resp_ctrl_tb;

  localparam int CPB = 8;
  localparam int TMO = 200;
  localparam logic [63:0] PUB = (64'd1 << 5) | (64'd1 << 37) | (64'd1 << 53);
  localparam logic [63:0] SUB = (64'd1 << 6) | (64'd1 << 38) | (64'd1 << 54);
  localparam int NV = 6;
  localparam logic [5:0] V_ID   [NV] = '{6'h05, 6'h25, 6'h35, 6'h06, 6'h26, 6'h36};
  localparam logic       V_PUB  [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [7:0] V_SEED [NV] = '{8'hF0, 8'h81, 8'h3C, 8'hC7, 8'h5A, 8'hEE};

  logic clk, rst_n, id_valid, app_we, lin_tx, busy, done, csum_err, bit_err, rx_valid;
  logic [5:0] id;
  logic [2:0] app_addr;
  logic [7:0] app_wdata, app_rdata;
  logic tb_drv;
  wire  lin_bus = lin_tx & tb_drv;

  int checks = 0, errors = 0, done_cnt = 0;
  bit finished = 0;
  logic [7:0] bytes [8];

  lin_resp_ctrl #(
    .CLKS_PER_BIT(CPB), .TIMEOUT_CLKS(TMO), .PUB_MASK(PUB), .SUB_MASK(SUB)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id(id), .app_we(app_we),
    .app_addr(app_addr), .app_wdata(app_wdata), .app_rdata(app_rdata),
    .lin_rx(lin_bus), .lin_tx(lin_tx), .busy(busy), .done(done),
    .csum_err(csum_err), .bit_err(bit_err), .rx_valid(rx_valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [5:0] i);
    case (i[5:4])
      2'b10:   return 4;
      2'b11:   return 8;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] ref_csum(input int n);
    logic [8:0] t;
    logic [7:0] s;
    s = 8'h00;
    for (int k = 0; k < n; k++) begin
      t = {1'b0, s} + {1'b0, bytes[k]};
      s = t[7:0] + {7'd0, t[8]};
    end
    return ~s;
  endfunction

  task automatic pulse_id(input logic [5:0] v);
    @(negedge clk); id = v; id_valid = 1'b1;
    @(negedge clk); id_valid = 1'b0;
  endtask

  task automatic write_buf(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); app_we = 1'b1; app_addr = 3'(k); app_wdata = bytes[k];
    end
    @(negedge clk); app_we = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      tb_drv = fr[k];
      repeat (CPB) @(negedge clk);
    end
    tb_drv = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cap_byte(output logic [7:0] b);
    int g;
    g = 0;
    while (lin_bus && g < 2000) begin @(negedge clk); g++; end
    repeat (CPB / 2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      repeat (CPB) @(negedge clk);
      b[k] = lin_bus;
    end
    repeat (CPB) @(negedge clk);
  endtask

  task automatic fill(input logic [7:0] seed, input int n);
    for (int k = 0; k < n; k++) bytes[k] = seed + 8'(k * 8'h4D);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cb;
    int n, d0, minb;
    rst_n = 1'b0; id_valid = 1'b0; id = '0; app_we = 1'b0; app_addr = '0;
    app_wdata = '0; tb_drv = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lin_tx", int'(lin_tx), 1);
    check("R1 busy/done", int'({busy, done}), 0);
    check("R1 flags", int'({csum_err, bit_err, rx_valid}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: publish and subscribe for each length code (R2 R3 R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      n = exp_len(V_ID[v]);
      fill(V_SEED[v], n);
      d0 = done_cnt;
      if (V_PUB[v]) begin
        write_buf(n);
        pulse_id(V_ID[v]);
        for (int k = 0; k < n; k++) begin
          cap_byte(cb);
          check($sformatf("R4 tx data id%0h b%0d", V_ID[v], k), int'(cb), int'(bytes[k]));
        end
        cap_byte(cb);
        check($sformatf("R5 tx csum id%0h", V_ID[v]), int'(cb), int'(ref_csum(n)));
        minb = 1;
        repeat (2 * CPB) begin @(negedge clk); if (!lin_bus) minb = 0; end
        check($sformatf("R3 no extra byte id%0h", V_ID[v]), minb, 1);
        check("R11 one done", done_cnt - d0, 1);
        check("R2 publish flags", int'({busy, bit_err}), 0);
      end else begin
        pulse_id(V_ID[v]);
        check("R2 subscribe busy", int'(busy), 1);
        for (int k = 0; k < n; k++) send_byte(bytes[k]);
        send_byte(ref_csum(n));
        repeat (2) @(negedge clk);
        check($sformatf("R6 rx_valid id%0h", V_ID[v]), int'({rx_valid, csum_err, busy}), 3'b100);
        check("R6 done", done_cnt - d0, 1);
        for (int k = 0; k < n; k++) begin
          app_addr = 3'(k);
          @(negedge clk);
          check($sformatf("R6 stored id%0h b%0d", V_ID[v], k), int'(app_rdata), int'(bytes[k]));
        end
      end
    end

    // R2 ignored identifier leaves state and bus untouched
    pulse_id(6'h07);
    minb = 1;
    repeat (3 * CPB) begin @(negedge clk); if (!lin_tx || busy) minb = 0; end
    check("R2 ignore idle", minb, 1);
    check("R2 ignore rx_valid kept", int'(rx_valid), 1);

    // R7 bad checksum
    fill(8'h12, 2);
    d0 = done_cnt;
    pulse_id(6'h06);
    send_byte(bytes[0]); send_byte(bytes[1]);
    send_byte(ref_csum(2) ^ 8'h01);
    repeat (2) @(negedge clk);
    check("R7 csum_err/rx_valid", int'({csum_err, rx_valid}), 2'b10);
    check("R7 done", done_cnt - d0, 1);

    // R8 readback mismatch on a recessive data bit
    bytes[0] = 8'hFF; bytes[1] = 8'h00;
    write_buf(2);
    d0 = done_cnt;
    pulse_id(6'h05);
    while (lin_bus) @(negedge clk);
    tb_drv = 1'b0;
    repeat (3 * CPB) @(negedge clk);
    tb_drv = 1'b1;
    repeat (CPB) @(negedge clk);
    check("R8 bit_err", int'(bit_err), 1);
    check("R8 stopped", int'({busy, lin_tx}), 2'b01);
    check("R8 no done", done_cnt - d0, 0);
    check("R11 csum_err cleared", int'(csum_err), 0);

    // R9 inter-byte timeout; R11 bit_err cleared by accepted id
    d0 = done_cnt;
    pulse_id(6'h06);
    check("R11 bit_err cleared", int'(bit_err), 0);
    send_byte(8'hA5);
    repeat (TMO + 20) @(negedge clk);
    check("R9 timeout idle", int'(busy), 0);
    check("R9 no done", done_cnt - d0, 0);
    check("R9 rx_valid", int'(rx_valid), 0);

    // R10 identifier while busy has no effect
    fill(8'h77, 2);
    d0 = done_cnt;
    pulse_id(6'h06);
    pulse_id(6'h05);
    minb = 1;
    repeat (2 * CPB) begin @(negedge clk); if (!lin_tx) minb = 0; end
    check("R10 no transmit", minb, 1);
    send_byte(bytes[0]); send_byte(bytes[1]);
    send_byte(ref_csum(2));
    repeat (2) @(negedge clk);
    check("R10 frame kept", int'({rx_valid, csum_err}), 2'b10);
    check("R10 done", done_cnt - d0, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule